// File: doc/BRIEF.md
# Register-Polled Display Output Port

This block gives one compositor channel a second way out. Instead of streaming composed pixels into a display FIFO, it parks them in a small internal queue and lets a reader pull them one register read at a time. Each read of the port register returns a pixel together with flags for data valid, queue empty and end of line. Frame start and line start are commands the reader writes to the same register.

A control word sets the line width, the frame height, an enable, a held soft reset, a one-shot frame mode and a packed mode. In packed mode each read carries two pixels reduced to 16 bits each, with no status. Pixels arrive from an upstream source over a valid/ready handshake. The port fetches only the pixels of the line that is open, so the reader paces the whole frame.

Top module: `pdp_port`

## Requirements
- R1: A read of the port register (address 1) in normal mode returns the RGB pixel in bits [23:0], a valid flag in bit 24, a queue-empty flag in bit 25, an end-of-line flag in bit 26 and zero in bits [31:27]. Pixels come out in the order the source delivered them.
- R2: A read pops a pixel only when it returns valid set. A normal-mode read with no pixel ready inside an open line returns exactly 0x0200_0000 and does not advance the line.
- R3: After the reader has taken the last of `width` pixels of a line, end-of-line reads as set. Exactly `width` pixels are fetched from the source per line, and `src_ready` stays low until a line start is accepted.
- R4: Writing the port register with bit 30 set requests a line start. It is accepted only while end-of-line is set within a running frame, and it is ignored mid-line.
- R5: Writing the port register with bit 31 set, while enabled, starts a frame. It empties the queue, clears end-of-line, zeroes the pixel and line counters and opens the first line. This applies mid-line too. A start request written in the same word has no further effect.
- R6: With control bit 28 set, a read returns the first pixel in bits [15:0] and the second in bits [31:16], each as {r[7:3], g[7:2], b[7:3]}, with no status bits. When a line has an odd width, the upper half of its final read is zero. A read with nothing ready returns zero.
- R7: With control bit 29 set, the port goes idle once the last line of `height` lines ends, and it ignores line starts until the next frame start. With bit 29 clear, a line start after the last line begins the next frame.
- R8: The control word at address 0 holds enable in bit 31, soft reset in bit 30, one-shot in bit 29, packed in bit 28, width in [23:12] and height in [11:0]. It reads back unchanged. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R9: While enable is clear, no pixel is fetched, frame and line starts are ignored, and reads return valid clear.
- R10: While the soft reset bit is set, the queue is emptied and the line state is cleared. Reads then return 0x0200_0000.
- R11: After `rst_n` is released, the control word reads zero, the port reads 0x0200_0000 and `src_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the control word, 1 the pixel port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_valid | input | 1 | Upstream pixel valid |
| src_ready | output | 1 | Port accepts a pixel this cycle |
| src_rgb | input | PIX_W | Upstream pixel, 8 bits each of R, G, B |

## Verification
The bench aims at these corner cases:
- A line start written mid-line must be ignored. A design that took it would restart its fetch count, so the line would yield more than `width` pixels and end-of-line would come late.
- A frame start mid-line must discard queued pixels. A design that kept them would hand out stale pixels ahead of the new frame's first one.
- Odd-width lines in packed mode must carry a zero upper half on their last read. A design that got this wrong would leak a pixel of the next line or steal one from it.
- In one-shot mode the port must stay idle after the last line. A design that kept `src_ready` high, or honoured a line start there, would run on into a second frame.
- Random frame sizes and gaps in the source also exercise empty reads, which must return valid clear and leave the pixel order intact.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
   localparam int DimW = 12;

   typedef struct packed {
      logic            en;
      logic            srst;
      logic            once;
      logic            pack;
      logic [DimW-1:0] width;
      logic [DimW-1:0] height;
   } ctl_t;

   // control word layout: 31 enable, 30 soft reset, 29 one-shot, 28 packed,
   // [23:12] width, [11:0] height
   function automatic ctl_t ctl_decode(input logic [31:0] w);
      ctl_t c;
      c.en     = w[31];
      c.srst   = w[30];
      c.once   = w[29];
      c.pack   = w[28];
      c.width  = w[23:12];
      c.height = w[11:0];
      return c;
   endfunction

   function automatic logic [15:0] rgb_to_565(input logic [23:0] p);
      return {p[23:19], p[15:10], p[7:3]};
   endfunction
endpackage

// File: rtl/pdp_fifo.sv
module pdp_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     push,
   input  logic [W-1:0]             din,
   input  logic                     pop,
   input  logic                     pop_two,
   output logic [W-1:0]             head0,
   output logic [W-1:0]             head1,
   output logic [$clog2(DEPTH):0]   count
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("pdp_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rp, wp;
   logic [AW:0]   pop_n;

   assign pop_n = pop ? (pop_two ? (AW+1)'(2) : (AW+1)'(1)) : '0;
   assign head0 = mem[rp];
   assign head1 = mem[rp + AW'(1)];

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else if (flush) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         rp    <= rp + pop_n[AW-1:0];
         count <= count + {{AW{1'b0}}, push} - pop_n;
      end
   end

   // R3
   fifo_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> (count < FULL || pop));
   // R2
   fifo_no_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> (count >= pop_n));
endmodule

// File: rtl/pdp_seq.sv
module pdp_seq #(
   parameter int DEPTH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  pdp_pkg::ctl_t          ctl,
   input  logic                   cmd_wr,
   input  logic                   cmd_vs,
   input  logic                   cmd_hs,
   input  logic                   rd_port,
   input  logic                   src_valid,
   input  logic [$clog2(DEPTH):0] fifo_cnt,
   output logic                   src_ready,
   output logic                   push,
   output logic                   pop,
   output logic                   pop_two,
   output logic                   flush,
   output logic                   valid,
   output logic                   eol
);
   import pdp_pkg::*;
   localparam int CW = $clog2(DEPTH);
   localparam logic [CW:0] FULL = (CW+1)'(DEPTH);

   logic            active_q, open_q, eol_q;
   logic [DimW-1:0] pcnt_q, fcnt_q, lcnt_q;
   logic            run, vs_go, hs_go, last_pix, last_line;
   logic [DimW-1:0] remain, step;
   logic [CW:0]     need;

   assign run       = ctl.en && !ctl.srst;
   assign vs_go     = run && cmd_wr && cmd_vs;
   assign hs_go     = run && cmd_wr && cmd_hs && !cmd_vs && eol_q && active_q;
   assign remain    = ctl.width - pcnt_q;
   assign pop_two   = ctl.pack && (remain >= DimW'(2));
   assign step      = pop_two ? DimW'(2) : DimW'(1);
   assign need      = pop_two ? (CW+1)'(2) : (CW+1)'(1);
   assign valid     = run && open_q && (fifo_cnt >= need);
   assign pop       = valid && rd_port && !vs_go;
   assign src_ready = run && open_q && (fcnt_q < ctl.width) && (fifo_cnt < FULL);
   assign push      = src_ready && src_valid && !vs_go;
   assign flush     = vs_go || ctl.srst;
   assign last_pix  = remain <= step;
   assign last_line = lcnt_q == (ctl.height - DimW'(1));
   assign eol       = eol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         open_q   <= 1'b0;
         eol_q    <= 1'b0;
         pcnt_q   <= '0;
         fcnt_q   <= '0;
         lcnt_q   <= '0;
      end else if (ctl.srst) begin
         active_q <= 1'b0;
         open_q   <= 1'b0;
         eol_q    <= 1'b0;
         pcnt_q   <= '0;
         fcnt_q   <= '0;
         lcnt_q   <= '0;
      end else if (vs_go) begin
         active_q <= 1'b1;
         open_q   <= 1'b1;
         eol_q    <= 1'b0;
         pcnt_q   <= '0;
         fcnt_q   <= '0;
         lcnt_q   <= '0;
      end else if (hs_go) begin
         open_q   <= 1'b1;
         eol_q    <= 1'b0;
         pcnt_q   <= '0;
         fcnt_q   <= '0;
      end else begin
         if (push) fcnt_q <= fcnt_q + DimW'(1);
         if (pop) begin
            if (last_pix) begin
               open_q <= 1'b0;
               eol_q  <= 1'b1;
               pcnt_q <= '0;
               if (last_line) begin
                  lcnt_q <= '0;
                  if (ctl.once) active_q <= 1'b0;
               end else begin
                  lcnt_q <= lcnt_q + DimW'(1);
               end
            end else begin
               pcnt_q <= pcnt_q + step;
            end
         end
      end
   end

   // R3
   eol_closes_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(eol_q && open_q));
   // R3
   last_pop_sets_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && last_pix && !vs_go) |=> (eol_q && !open_q));
   // R4
   early_hs_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cmd_wr && cmd_hs && !cmd_vs && !eol_q && !pop) |=> ($stable(pcnt_q) && $stable(lcnt_q)));
   // R5
   vs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vs_go |=> (open_q && pcnt_q == '0 && lcnt_q == '0 && fcnt_q == '0));
   // R7
   oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && last_pix && last_line && ctl.once && !vs_go) |=> !active_q);
endmodule

// File: rtl/pdp_fmt.sv
module pdp_fmt #(
   parameter int PIX_W = 24
) (
   input  logic             pack,
   input  logic             valid,
   input  logic             two,
   input  logic             eol,
   input  logic             empty,
   input  logic [PIX_W-1:0] head0,
   input  logic [PIX_W-1:0] head1,
   output logic [31:0]      word
);
   initial begin
      assert (PIX_W == 24) else $error("pdp_fmt: PIX_W must be 24");
   end

   logic [15:0] lane [2];

   for (genvar i = 0; i < 2; i++) begin : g_lane
      if (i == 0) begin : g_first
         assign lane[i] = pdp_pkg::rgb_to_565(head0);
      end else begin : g_second
         assign lane[i] = two ? pdp_pkg::rgb_to_565(head1) : 16'h0000;
      end
   end

   always_comb begin
      if (pack) word = valid ? {lane[1], lane[0]} : 32'h0;
      else      word = {5'b0, eol, empty, valid, valid ? head0 : 24'h0};
   end
endmodule

// File: rtl/pdp_port.sv
module pdp_port #(
   parameter int FIFO_DEPTH = 4,
   parameter int PIX_W      = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             src_valid,
   output logic             src_ready,
   input  logic [PIX_W-1:0] src_rgb
);
   localparam int CW = $clog2(FIFO_DEPTH);

   logic [31:0]      ctl_q, port_word;
   pdp_pkg::ctl_t    ctl;
   logic             push, pop, pop_two, flush, valid, eol;
   logic [PIX_W-1:0] head0, head1;
   logic [CW:0]      fifo_cnt;

   assign ctl = pdp_pkg::ctl_decode(ctl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ctl_q <= '0;
      else if (bus_wr && !bus_addr) ctl_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= bus_addr ? port_word : ctl_q;
   end

   pdp_seq #(.DEPTH(FIFO_DEPTH)) seq_i (
      .clk(clk), .rst_n(rst_n), .ctl(ctl),
      .cmd_wr(bus_wr && bus_addr), .cmd_vs(bus_wdata[31]), .cmd_hs(bus_wdata[30]),
      .rd_port(bus_rd && bus_addr), .src_valid(src_valid), .fifo_cnt(fifo_cnt),
      .src_ready(src_ready), .push(push), .pop(pop), .pop_two(pop_two),
      .flush(flush), .valid(valid), .eol(eol)
   );

   pdp_fifo #(.DEPTH(FIFO_DEPTH), .W(PIX_W)) fifo_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .din(src_rgb),
      .pop(pop), .pop_two(pop_two), .head0(head0), .head1(head1), .count(fifo_cnt)
   );

   pdp_fmt #(.PIX_W(PIX_W)) fmt_i (
      .pack(ctl.pack), .valid(valid), .two(pop_two), .eol(eol),
      .empty(fifo_cnt == '0), .head0(head0), .head1(head1), .word(port_word)
   );
endmodule

// File: tb/pdp_port_tb_top.sv
module pdp_port_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [31:0] VS = 32'h8000_0000;
   localparam logic [31:0] HS = 32'h4000_0000;
   localparam logic [31:0] EMPTY_ONLY = 32'h0200_0000;
   localparam logic [31:0] EOL_EMPTY  = 32'h0600_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        src_valid = 1'b0, src_ready;
   logic [23:0] src_rgb;

   int n_chk = 0, n_fail = 0, seq = 0, line_hs = 0;
   logic [23:0] mq[$];
   logic [31:0] ctl_m = '0;
   bit rand_valid = 1'b0;

   pdp_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
      .src_ready(src_ready), .src_rgb(src_rgb)
   );

   always #2.5 clk = ~clk;

   function automatic logic [23:0] pix(int s);
      logic [7:0] b;
      b = s[7:0];
      return {b | 8'h80, b ^ 8'h5a, b + 8'h33};
   endfunction

   function automatic logic [15:0] p565(logic [23:0] p);
      return {p[23:19], p[15:10], p[7:3]};
   endfunction

   function automatic logic [31:0] mk_ctl(bit en, bit srst, bit one, bit pk, int w, int h);
      return {en, srst, one, pk, 4'h0, w[11:0], h[11:0]};
   endfunction

   assign src_rgb = pix(seq);

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // one clock; the model mirrors what the requirements say happens at the edge
   task automatic cyc();
      bit hs, vs, on;
      if (rand_valid) src_valid = ($urandom_range(3) != 0);
      hs = src_valid && src_ready;
      on = ctl_m[31] && !ctl_m[30];
      vs = bus_wr && bus_addr && bus_wdata[31] && on;
      @(posedge clk);
      #1;
      if (hs) begin
         if (!vs) begin
            mq.push_back(pix(seq));
            line_hs++;
         end
         seq++;
      end
      if (vs || ctl_m[30]) mq.delete();
      if (bus_wr && !bus_addr) ctl_m = bus_wdata;
   endtask

   task automatic wr(bit a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(bit a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      cyc();
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) cyc();
   endtask

   // reads n pixels of the current line (n is what remains of it in packed mode)
   task automatic take_px(int n, bit pk, string req);
      logic [31:0] d, e;
      logic [23:0] e0, e1;
      int got = 0;
      int tries = 0;
      while (got < n && tries < 400) begin
         rd(1'b1, d);
         tries++;
         if (!pk) begin
            if (d[24]) begin
               if (mq.size() == 0) begin
                  check(1'b0, req, d, 32'h0);
                  got++;
               end else begin
                  e0 = mq.pop_front();
                  check(d == {8'h01, e0}, req, d, {8'h01, e0});
                  got++;
               end
            end else begin
               check(d == EMPTY_ONLY, "R2", d, EMPTY_ONLY);
            end
         end else if (d != 32'h0) begin
            if (n - got >= 2 && mq.size() >= 2) begin
               e0 = mq.pop_front();
               e1 = mq.pop_front();
               e = {p565(e1), p565(e0)};
               got += 2;
            end else if (mq.size() >= 1) begin
               e0 = mq.pop_front();
               e = {16'h0, p565(e0)};
               got++;
            end else begin
               e = 32'h0;
               got++;
            end
            check(d == e, req, d, e);
         end
      end
      check(got == n, req, got, n);
   endtask

   task automatic end_line(int w, bit pk);
      logic [31:0] d;
      idle(3);
      check(line_hs == w, "R3", line_hs, w);
      check(src_ready == 1'b0, "R3", src_ready, 0);
      rd(1'b1, d);
      if (!pk) check(d == EOL_EMPTY, "R3", d, EOL_EMPTY);
      else     check(d == 32'h0, "R6", d, 0);
   endtask

   task automatic run_frame(int w, int h, bit pk, bit one);
      wr(1'b0, mk_ctl(1, 0, one, pk, w, h));
      wr(1'b1, VS);
      line_hs = 0;
      for (int l = 0; l < h; l++) begin
         if (l > 0) begin
            wr(1'b1, HS);
            line_hs = 0;
         end
         take_px(w, pk, pk ? "R6" : "R1");
         end_line(w, pk);
      end
   endtask

   initial begin : watchdog
      #(5 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL all: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      rd(1'b1, d); check(d == EMPTY_ONLY, "R11", d, EMPTY_ONLY);
      rd(1'b0, d); check(d == 32'h0, "R11", d, 0);
      check(src_ready == 1'b0, "R11", src_ready, 0);

      // R8 control readback
      wr(1'b0, mk_ctl(1, 0, 0, 0, 5, 2));
      rd(1'b0, d); check(d == mk_ctl(1, 0, 0, 0, 5, 2), "R8", d, mk_ctl(1, 0, 0, 0, 5, 2));

      // R2 empty read does not advance
      wr(1'b1, VS); line_hs = 0;
      idle(4);
      rd(1'b1, d); check(d == EMPTY_ONLY, "R2", d, EMPTY_ONLY);
      src_valid = 1'b1;
      idle(8);

      // R4 early line start ignored
      take_px(2, 0, "R1");
      wr(1'b1, HS);
      take_px(3, 0, "R4");
      end_line(5, 0);
      wr(1'b1, HS); line_hs = 0;
      idle(8);
      take_px(5, 0, "R1");
      end_line(5, 0);
      // R7 continuous wrap into next frame
      wr(1'b1, HS); line_hs = 0;
      idle(8);
      take_px(5, 0, "R7");
      end_line(5, 0);

      // R5 mid-line frame start
      wr(1'b1, VS); line_hs = 0;
      idle(8);
      take_px(2, 0, "R5");
      wr(1'b1, VS); line_hs = 0;
      idle(8);
      take_px(5, 0, "R5");
      end_line(5, 0);

      // R6 packed, odd and even widths
      run_frame(3, 1, 1, 0);
      run_frame(4, 2, 1, 0);

      // R7 one-shot stops after the frame
      run_frame(2, 2, 0, 1);
      wr(1'b1, HS);
      idle(8);
      check(src_ready == 1'b0, "R7", src_ready, 0);
      rd(1'b1, d); check(d == EOL_EMPTY, "R7", d, EOL_EMPTY);
      wr(1'b1, VS); line_hs = 0;
      idle(8);
      take_px(2, 0, "R7");
      end_line(2, 0);

      // R9 disabled: frame start ignored
      wr(1'b0, mk_ctl(0, 0, 0, 0, 4, 1));
      wr(1'b1, VS);
      idle(6);
      check(src_ready == 1'b0, "R9", src_ready, 0);
      rd(1'b1, d); check(d == EOL_EMPTY, "R9", d, EOL_EMPTY);

      // R10 soft reset mid-line
      wr(1'b0, mk_ctl(1, 0, 0, 0, 4, 1));
      wr(1'b1, VS); line_hs = 0;
      idle(8);
      take_px(1, 0, "R1");
      wr(1'b0, mk_ctl(1, 1, 0, 0, 4, 1));
      idle(2);
      check(src_ready == 1'b0, "R10", src_ready, 0);
      rd(1'b1, d); check(d == EMPTY_ONLY, "R10", d, EMPTY_ONLY);
      wr(1'b0, mk_ctl(1, 0, 0, 0, 4, 1));
      idle(4);
      rd(1'b1, d); check(d == EMPTY_ONLY, "R10", d, EMPTY_ONLY);

      // random frames, both modes, source gaps
      void'($urandom(32'd1234));
      rand_valid = 1'b1;
      for (int k = 0; k < 24; k++) begin
         run_frame($urandom_range(9, 1), $urandom_range(3, 1),
                   $urandom_range(1), $urandom_range(1));
      end
      rand_valid = 1'b0;
      src_valid = 1'b1;

      summary();
      $finish;
   end
endmodule